// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask Router

This block gathers a set of level-sensitive device interrupt lines into one shared raw request register. It gives each of four processors a private mask, keeps a per-processor masked copy equal to mask AND raw, and drives one interrupt line per processor. That line is high whenever any bit of its masked copy is set. Whenever a masked bit changes, the block produces a post event (the bit went 0 to 1) or a clear event (1 to 0). The event carries the processor and bit index, and the events leave one per cycle through a priority scan.

Software reaches the block through a 64-bit register bus. A request is a valid/ready beat. The block holds ready high at all times, so a request is accepted in every cycle in which valid is high. Each accepted request gets exactly one response beat in the next cycle, carrying read data or an error flag. The response has no back-pressure: the requester must take it. A status register reports which processor made the access and holds a timer interrupt flag. The timer pulse input sets the flag, and software clears it through the bus.

Register index is (address - BASE) >> 6. Index 0 is the control/status register. Index 1 is the status register. Indices 2..5 are the masks for processors 0..3. Indices 6..9 are the masked copies for processors 0..3. Index 10 is the raw request register.

Top module: `irq_mask_router`

## Requirements
- R1: After reset, every mask, the raw register, every masked copy and the timer flag read as zero; cpu_irq, evt_valid and timer_clr_evt are low.
- R2: req_ready is always 1. Every accepted request gets rsp_valid high in the following cycle, and only then. Read data is the register value at acceptance and is zero on an error.
- R3: Only req_size = 3 (eight bytes) is legal. Any other size, and any index above 10, gives rsp_err = 1 and changes no state.
- R4: A mask write replaces that processor's mask. The masked copy of every processor reads back as its mask AND the raw register from the edge that accepts the write.
- R5: The raw register takes dev_irq at each clock edge. cpu_irq[c] is the OR of processor c's masked copy.
- R6: Each masked bit that goes from 0 to 1 yields one post event (evt_kind = 0). Each bit that goes from 1 to 0 yields one clear event (evt_kind = 1). Rewriting a mask with its current value yields no event.
- R7: Events leave one per cycle, starting the cycle after the change. All pending posts go before pending clears. Within a kind, the lower processor goes first, then the lower bit.
- R8: A masked bit that reverses before its pending event has left cancels that event, and no opposite event is produced.
- R9: A read of the status register returns the timer flag at bit 4, ORed with req_cpu in bits [1:0]. A read of the control/status register returns zero.
- R10: timer_tick sets the timer flag. A status write with bit 4 set clears the flag and pulses timer_clr_evt for one cycle. A status write with bit 4 clear gives an error and leaves the flag unchanged. If a tick and a clear land in the same cycle, the flag stays set.
- R11: Writes to the control/status register, any masked copy, or the raw register give rsp_err = 1 and change nothing.
- R12: If a mask write and a dev_irq change land in the same edge, both take effect. The events follow from the combined result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (constant 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | log2 of access bytes |
| req_cpu | input | CPU_W | Identifier of the requesting processor |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response beat |
| rsp_err | output | 1 | Response error |
| rsp_rdata | output | DATA_W | Read data |
| dev_irq | input | NUM_SRC | Device request levels |
| timer_tick | input | 1 | Sets the timer flag |
| timer_irq | output | 1 | Timer flag |
| timer_clr_evt | output | 1 | One-cycle pulse when the timer flag is cleared |
| cpu_irq | output | NUM_CPU | Per-processor interrupt |
| evt_valid | output | 1 | Event pulse |
| evt_kind | output | 1 | 0 = post, 1 = clear |
| evt_cpu | output | CPU_W | Event processor |
| evt_bit | output | SRC_W | Event bit index |

## Verification
Two pairs of functions can land on the same edge. In the first, a mask write and a device request edge on the same bit: the bench drives both in one cycle. It expects a single post event for that processor and the others masking that bit, with no clear. In the second, a timer tick and a clearing status write in one cycle: the flag must stay set while the clear pulse still fires. A backlog-induced cancellation case also checks that a reversal racing the event scan emits neither event.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;
  typedef enum logic [2:0] {
    RK_CSR,
    RK_MISC,
    RK_MASK,
    RK_MASKED,
    RK_RAW,
    RK_NONE
  } reg_kind_e;

  localparam int         TIMER_BIT  = 4;
  localparam logic [1:0] SIZE_DWORD = 2'd3;
endpackage

// File: rtl/irq_bus_decode.sv
`timescale 1ns/1ps
module irq_bus_decode
  import irq_router_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter logic [15:0]     BASE        = 16'h0000,
  parameter int              STRIDE_LOG2 = 6,
  parameter int              NUM_CPU     = 4
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [1:0]                 size,
  input  logic                       write,
  input  logic                       clr_bit,
  output reg_kind_e                  kind,
  output logic [$clog2(NUM_CPU)-1:0] cpu_sel,
  output logic                       err
);
  localparam int CPU_W = $clog2(NUM_CPU);
  localparam logic [ADDR_W-1:0] IDX_MASK   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] IDX_MASKED = ADDR_W'(2 + NUM_CPU);
  localparam logic [ADDR_W-1:0] IDX_RAW    = ADDR_W'(2 + 2 * NUM_CPU);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] idx;

  assign offset = addr - ADDR_W'(BASE);
  assign idx    = offset >> STRIDE_LOG2;

  always_comb begin
    kind    = RK_NONE;
    cpu_sel = '0;
    if (idx == '0) begin
      kind = RK_CSR;
    end else if (idx == ADDR_W'(1)) begin
      kind = RK_MISC;
    end else if (idx >= IDX_MASK && idx < IDX_MASKED) begin
      kind    = RK_MASK;
      cpu_sel = CPU_W'(idx - IDX_MASK);
    end else if (idx >= IDX_MASKED && idx < IDX_RAW) begin
      kind    = RK_MASKED;
      cpu_sel = CPU_W'(idx - IDX_MASKED);
    end else if (idx == IDX_RAW) begin
      kind = RK_RAW;
    end
  end

  always_comb begin
    err = 1'b0;
    if (size != SIZE_DWORD || kind == RK_NONE) begin
      err = 1'b1;
    end else if (write) begin
      case (kind)
        RK_CSR, RK_MASKED, RK_RAW: err = 1'b1;
        RK_MISC:                   err = !clr_bit;
        default:                   err = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
module irq_mask_bank #(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SRC-1:0]                dev_irq,
  input  logic                              mask_we,
  input  logic [$clog2(NUM_CPU)-1:0]        mask_cpu,
  input  logic [NUM_SRC-1:0]                mask_wdata,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_q,
  output logic [NUM_SRC-1:0]                raw_q,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   masked_q,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   rise,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   fall
);
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_n;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] masked_n;

  // New mask and new raw are combined so a same-edge write and edge agree.
  always_comb begin
    mask_n = mask_q;
    if (mask_we) mask_n[mask_cpu] = mask_wdata;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign masked_n[c] = mask_n[c] & dev_irq;
    assign rise[c]     = masked_n[c] & ~masked_q[c];
    assign fall[c]     = masked_q[c] & ~masked_n[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      raw_q    <= '0;
      masked_q <= '0;
    end else begin
      mask_q   <= mask_n;
      raw_q    <= dev_irq;
      masked_q <= masked_n;
    end
  end
endmodule

// File: rtl/irq_event_scan.sv
`timescale 1ns/1ps
module irq_event_scan #(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0]  rise,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0]  fall,
  output logic                             evt_valid,
  output logic                             evt_kind,
  output logic [$clog2(NUM_CPU)-1:0]       evt_cpu,
  output logic [$clog2(NUM_SRC)-1:0]       evt_bit
);
  localparam int CPU_W = $clog2(NUM_CPU);
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int PER   = NUM_CPU * NUM_SRC;
  localparam int TOT   = 2 * PER;
  localparam int IDX_W = 1 + CPU_W + SRC_W;

  logic [PER-1:0] pend_post, pend_clr;
  logic [PER-1:0] rise_f, fall_f;
  logic [PER-1:0] post_left, clr_left, post_n, clr_n;
  logic [TOT-1:0] pend_all, served;
  logic [IDX_W-1:0] pick;
  logic             hit;

  assign rise_f   = rise;
  assign fall_f   = fall;
  assign pend_all = {pend_clr, pend_post};

  // Lowest index wins: posts sit below clears, then cpu, then bit.
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = TOT - 1; i >= 0; i--) begin
      if (pend_all[i]) begin
        hit  = 1'b1;
        pick = IDX_W'(i);
      end
    end
  end

  assign served    = hit ? ({{(TOT-1){1'b0}}, 1'b1} << pick) : '0;
  assign post_left = pend_post & ~served[PER-1:0];
  assign clr_left  = pend_clr  & ~served[TOT-1:PER];
  // A reversal of a still-pending transition cancels both.
  assign post_n    = (post_left & ~fall_f) | (rise_f & ~clr_left);
  assign clr_n     = (clr_left & ~rise_f)  | (fall_f & ~post_left);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_post <= '0;
      pend_clr  <= '0;
      evt_valid <= 1'b0;
      evt_kind  <= 1'b0;
      evt_cpu   <= '0;
      evt_bit   <= '0;
    end else begin
      pend_post <= post_n;
      pend_clr  <= clr_n;
      evt_valid <= hit;
      evt_kind  <= pick[IDX_W-1];
      evt_cpu   <= pick[SRC_W +: CPU_W];
      evt_bit   <= pick[SRC_W-1:0];
    end
  end
endmodule

// File: rtl/irq_mask_router.sv
`timescale 1ns/1ps
module irq_mask_router
  import irq_router_pkg::*;
#(
  parameter int          NUM_CPU = 4,
  parameter int          NUM_SRC = 64,
  parameter int          DATA_W  = 64,
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] BASE    = 16'h0000,
  localparam int         CPU_W   = $clog2(NUM_CPU),
  localparam int         SRC_W   = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [NUM_SRC-1:0] dev_irq,
  input  logic              timer_tick,
  output logic              timer_irq,
  output logic              timer_clr_evt,
  output logic [NUM_CPU-1:0] cpu_irq,
  output logic              evt_valid,
  output logic              evt_kind,
  output logic [CPU_W-1:0]  evt_cpu,
  output logic [SRC_W-1:0]  evt_bit
);
  reg_kind_e        dec_kind;
  logic [CPU_W-1:0] dec_cpu;
  logic             dec_err;
  logic             accept, mask_we, misc_clr;
  logic [DATA_W-1:0] rd_value;

  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q, masked_q, rise, fall;
  logic [NUM_SRC-1:0]              raw_q;
  logic [NUM_CPU*NUM_SRC-1:0]      masked_flat;
  logic                            timer_flag;

  assign req_ready   = 1'b1;
  assign accept      = req_valid & req_ready;
  assign masked_flat = masked_q;

  irq_bus_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE_LOG2(6), .NUM_CPU(NUM_CPU)
  ) u_decode (
    .addr(req_addr), .size(req_size), .write(req_write),
    .clr_bit(req_wdata[TIMER_BIT]),
    .kind(dec_kind), .cpu_sel(dec_cpu), .err(dec_err)
  );

  assign mask_we  = accept & req_write & !dec_err & (dec_kind == RK_MASK);
  assign misc_clr = accept & req_write & !dec_err & (dec_kind == RK_MISC);

  irq_mask_bank #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq),
    .mask_we(mask_we), .mask_cpu(dec_cpu), .mask_wdata(req_wdata[NUM_SRC-1:0]),
    .mask_q(mask_q), .raw_q(raw_q), .masked_q(masked_q),
    .rise(rise), .fall(fall)
  );

  irq_event_scan #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_scan (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_cpu(evt_cpu), .evt_bit(evt_bit)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
    assign cpu_irq[c] = |masked_q[c];
  end

  always_comb begin
    rd_value = '0;
    case (dec_kind)
      RK_MISC:   rd_value = (DATA_W'(timer_flag) << TIMER_BIT) | DATA_W'(req_cpu);
      RK_MASK:   rd_value = DATA_W'(mask_q[dec_cpu]);
      RK_MASKED: rd_value = DATA_W'(masked_q[dec_cpu]);
      RK_RAW:    rd_value = DATA_W'(raw_q);
      default:   rd_value = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_flag    <= 1'b0;
      timer_clr_evt <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_err       <= 1'b0;
      rsp_rdata     <= '0;
    end else begin
      if (timer_tick)    timer_flag <= 1'b1;
      else if (misc_clr) timer_flag <= 1'b0;
      timer_clr_evt <= misc_clr;
      rsp_valid     <= accept;
      rsp_err       <= accept & dec_err;
      rsp_rdata     <= (accept & !req_write & !dec_err) ? rd_value : '0;
    end
  end

  assign timer_irq = timer_flag;
endmodule

// File: rtl/irq_mask_router_chk.sv
`timescale 1ns/1ps
module irq_mask_router_chk #(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic [1:0]                   req_size,
  input logic                         rsp_valid,
  input logic                         rsp_err,
  input logic                         evt_valid,
  input logic                         evt_kind,
  input logic [$clog2(NUM_CPU)-1:0]   evt_cpu,
  input logic [$clog2(NUM_SRC)-1:0]   evt_bit,
  input logic                         timer_tick,
  input logic                         timer_irq,
  input logic                         timer_clr_evt,
  input logic [NUM_CPU-1:0]           cpu_irq,
  input logic [NUM_SRC-1:0]           raw_q,
  input logic [NUM_CPU*NUM_SRC-1:0]   masked_flat
);
  logic [NUM_CPU*NUM_SRC-1:0] masked_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) masked_prev <= '0;
    else        masked_prev <= masked_flat;
  end

  assert_rsp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_narrow_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd3) |=> rsp_err);
  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q == '0) |-> (cpu_irq == '0));
  assert_post_backed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_kind) |-> masked_prev[{evt_cpu, evt_bit}]);
  assert_clear_backed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind) |-> !masked_prev[{evt_cpu, evt_bit}]);
  assert_timer_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_clr_evt && !$past(timer_tick)) |-> !timer_irq);
endmodule

bind irq_mask_router irq_mask_router_chk #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_cpu(evt_cpu), .evt_bit(evt_bit),
  .timer_tick(timer_tick), .timer_irq(timer_irq), .timer_clr_evt(timer_clr_evt),
  .cpu_irq(cpu_irq), .raw_q(raw_q), .masked_flat(masked_flat)
);

// File: tb/irq_mask_router_test.sv
`timescale 1ns/1ps
module irq_mask_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = 2'd3;
  logic [1:0]  req_cpu = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [63:0] dev_irq = '0;
  logic        timer_tick = 1'b0;
  logic        timer_irq, timer_clr_evt, evt_valid, evt_kind;
  logic [3:0]  cpu_irq;
  logic [1:0]  evt_cpu;
  logic [5:0]  evt_bit;

  int n_chk = 0, n_fail = 0, tclr_cnt = 0;
  int evq[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_mask_router uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_cpu(req_cpu), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .dev_irq(dev_irq),
    .timer_tick(timer_tick), .timer_irq(timer_irq), .timer_clr_evt(timer_clr_evt),
    .cpu_irq(cpu_irq), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_cpu(evt_cpu), .evt_bit(evt_bit)
  );

  always @(negedge clk) begin
    if (evt_valid) evq.push_back(int'(evt_kind) * 1000 + int'(evt_cpu) * 100 + int'(evt_bit));
    if (timer_clr_evt) tclr_cnt++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [1:0] cpu, input int idx,
                     input logic [1:0] sz, input logic [63:0] wd,
                     output logic err, output logic [63:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cpu = cpu;
    req_addr = 16'(idx * 64); req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 response beat", 64'(rsp_valid), 64'd1);
    err = rsp_err; rd = rsp_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp_events(input string tag, input int exp[$]);
    chk({tag, " event count"}, 64'(evq.size()), 64'(exp.size()));
    if (evq.size() == exp.size())
      foreach (exp[i]) chk({tag, " event"}, 64'(evq[i]), 64'(exp[i]));
    evq.delete();
  endtask

  function automatic logic [63:0] pat(input int c);
    case (c)
      0: return 64'h5555_5555_5555_5555;
      1: return 64'hAAAA_AAAA_AAAA_AAAA;
      2: return 64'hFFFF_0000_FFFF_0000;
      default: return 64'h0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic e;
    logic [63:0] rd;
    int exp[$];
    logic [63:0] r_pat, m_new;

    waitc(3);
    rst_n = 1'b1;
    waitc(1);
    // R1 reset state
    chk("R1 cpu_irq", 64'(cpu_irq), 0);
    chk("R1 evt_valid", 64'(evt_valid), 0);
    chk("R1 timer_irq", 64'(timer_irq), 0);
    chk("R2 idle rsp", 64'(rsp_valid), 0);
    chk("R2 ready", 64'(req_ready), 1);
    for (int i = 2; i <= 10; i++) begin
      bus(1'b0, 2'd0, i, 2'd3, '0, e, rd);
      chk("R1 register zero", rd, 0);
      chk("R1 no error", 64'(e), 0);
    end

    // R9 status and control reads
    bus(1'b0, 2'd2, 0, 2'd3, '0, e, rd);
    chk("R9 control reads zero", rd, 0);
    for (int c = 0; c < 4; c++) begin
      bus(1'b0, 2'(c), 1, 2'd3, '0, e, rd);
      chk("R9 status id", rd, 64'(c));
    end

    // R3 illegal sizes and indices
    for (int s = 0; s < 3; s++) begin
      bus(1'b0, 2'd0, 2, 2'(s), '0, e, rd);
      chk("R3 narrow err", 64'(e), 1);
      chk("R2 data zero on err", rd, 0);
    end
    bus(1'b1, 2'd0, 2, 2'd1, 64'hFF, e, rd);
    chk("R3 narrow write err", 64'(e), 1);
    bus(1'b0, 2'd0, 2, 2'd3, '0, e, rd);
    chk("R3 mask unchanged", rd, 0);
    for (int i = 11; i < 16; i++) begin
      bus(1'b0, 2'd0, i, 2'd3, '0, e, rd);
      chk("R3 unknown index err", 64'(e), 1);
    end

    // R4 masks for the sweep, read back
    for (int c = 0; c < 4; c++) begin
      bus(1'b1, 2'd0, 2 + c, 2'd3, pat(c), e, rd);
      chk("R4 mask write ok", 64'(e), 0);
      bus(1'b0, 2'd0, 2 + c, 2'd3, '0, e, rd);
      chk("R4 mask readback", rd, pat(c));
    end
    waitc(4);
    chk("R6 no events with zero raw", 64'(evq.size()), 0);

    // R5/R6/R7 sweep of every source bit
    for (int b = 0; b < 64; b++) begin
      logic [3:0] ex_irq;
      ex_irq = '0;
      exp.delete();
      @(negedge clk); dev_irq[b] = 1'b1;
      waitc(8);
      for (int c = 0; c < 4; c++)
        if (pat(c)[b]) begin exp.push_back(c * 100 + b); ex_irq[c] = 1'b1; end
      cmp_events("R6 R7 post sweep", exp);
      chk("R5 cpu_irq sweep", 64'(cpu_irq), 64'(ex_irq));
      exp.delete();
      @(negedge clk); dev_irq[b] = 1'b0;
      waitc(8);
      for (int c = 0; c < 4; c++)
        if (pat(c)[b]) exp.push_back(1000 + c * 100 + b);
      cmp_events("R6 R7 clear sweep", exp);
      chk("R5 cpu_irq released", 64'(cpu_irq), 0);
    end

    // R6/R7 mask rewrite against a raw pattern
    r_pat = 64'h0F0F_00FF_1234_8001;
    @(negedge clk); dev_irq = r_pat;
    waitc(140);
    evq.delete();
    bus(1'b0, 2'd0, 10, 2'd3, '0, e, rd);
    chk("R5 raw readback", rd, r_pat);
    m_new = 64'h00FF_FF00_0F0F_F0F0;
    bus(1'b1, 2'd0, 3, 2'd3, m_new, e, rd);
    waitc(140);
    exp.delete();
    for (int b = 0; b < 64; b++)
      if (m_new[b] & ~pat(1)[b] & r_pat[b]) exp.push_back(100 + b);
    for (int b = 0; b < 64; b++)
      if (~m_new[b] & pat(1)[b] & r_pat[b]) exp.push_back(1100 + b);
    cmp_events("R6 R7 mask rewrite", exp);
    bus(1'b0, 2'd0, 7, 2'd3, '0, e, rd);
    chk("R4 masked readback", rd, m_new & r_pat);
    bus(1'b1, 2'd0, 3, 2'd3, m_new, e, rd);
    waitc(6);
    exp.delete();
    cmp_events("R6 same-value rewrite", exp);

    // R11 rejected writes
    bus(1'b1, 2'd0, 0, 2'd3, 64'hFFFF, e, rd);
    chk("R11 control write err", 64'(e), 1);
    bus(1'b1, 2'd0, 7, 2'd3, '1, e, rd);
    chk("R11 masked write err", 64'(e), 1);
    bus(1'b1, 2'd0, 10, 2'd3, '0, e, rd);
    chk("R11 raw write err", 64'(e), 1);
    bus(1'b0, 2'd0, 10, 2'd3, '0, e, rd);
    chk("R11 raw unchanged", rd, r_pat);
    bus(1'b0, 2'd0, 7, 2'd3, '0, e, rd);
    chk("R11 masked unchanged", rd, m_new & r_pat);

    // R12 mask write and request edge on one edge
    @(negedge clk); dev_irq = '0;
    waitc(140);
    evq.delete();
    bus(1'b1, 2'd0, 3, 2'd3, pat(1), e, rd);
    bus(1'b1, 2'd0, 5, 2'd3, '0, e, rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'(5 * 64);
    req_size = 2'd3; req_wdata = 64'h200; dev_irq[9] = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waitc(6);
    exp.delete();
    exp.push_back(100 + 9);
    exp.push_back(300 + 9);
    cmp_events("R12 same-edge write and edge", exp);
    chk("R12 cpu_irq", 64'(cpu_irq), 64'b1010);

    // R8 cancellation under a backlog
    @(negedge clk); dev_irq = '0;
    waitc(8);
    evq.delete();
    for (int c = 1; c < 4; c++) bus(1'b1, 2'd0, 2 + c, 2'd3, '0, e, rd);
    bus(1'b1, 2'd0, 2, 2'd3, '1, e, rd);
    waitc(2);
    evq.delete();
    @(negedge clk); dev_irq = '1;
    @(negedge clk); dev_irq[63] = 1'b0;
    waitc(80);
    exp.delete();
    for (int b = 0; b < 63; b++) exp.push_back(b);
    cmp_events("R8 reversal cancels", exp);

    // R10 timer flag
    @(negedge clk); timer_tick = 1'b1;
    @(negedge clk); timer_tick = 1'b0;
    chk("R10 tick sets flag", 64'(timer_irq), 1);
    bus(1'b0, 2'd3, 1, 2'd3, '0, e, rd);
    chk("R9 status with flag", rd, 64'h13);
    bus(1'b1, 2'd0, 1, 2'd3, 64'h0, e, rd);
    chk("R10 write without bit 4 err", 64'(e), 1);
    chk("R10 flag kept", 64'(timer_irq), 1);
    tclr_cnt = 0;
    bus(1'b1, 2'd0, 1, 2'd3, 64'h10, e, rd);
    chk("R10 clear ok", 64'(e), 0);
    chk("R10 flag cleared", 64'(timer_irq), 0);
    waitc(2);
    chk("R10 one clear pulse", 64'(tclr_cnt), 1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'(64);
    req_size = 2'd3; req_wdata = 64'h10; timer_tick = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; timer_tick = 1'b0;
    chk("R10 tick wins over clear", 64'(timer_irq), 1);
    chk("R10 pulse with tick", 64'(timer_clr_evt), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule